// File: doc/BRIEF.md
# Audio Coprocessor Memory Map with Boot Overlay and Mailbox

This block decodes the address space of a small audio coprocessor. It holds the local RAM. In the top 64 bytes of the space it lays a boot ROM over that RAM, and this overlay can be switched on and off. At a fixed low-page window it provides four byte-wide mailbox ports that a host CPU shares with the coprocessor.

The coprocessor reaches everything through one address/data bus with read and write strobes. Read data appears one cycle after the read strobe. The host sees only the mailbox. It addresses the mailbox with a 2-bit port index and uses its own read and write strobes.

Each mailbox port is two independent byte latches, one for each direction. The byte one side writes is the byte the other side reads. A write never changes what the writing side reads back at the same port. The boot ROM is not a fixed region: a bit in a control byte can switch the overlay off so that the RAM underneath shows through.

The address width is a parameter, `ADDR_W` (default 11). The ROM always sits at `2**ADDR_W - 64`, which is 0xFFC0 with a 16-bit bus and 0x7C0 with the default.

Top module: `amap_top`

## Requirements
- R1: While reset is asserted, and afterwards until a control write, the overlay is enabled. Reset clears all four host-to-coprocessor latches and all four coprocessor-to-host latches to 0x00, and clears both read-data outputs to 0x00.
- R2: Reads on both sides behave the same way:
  - `cp_rdata` takes the addressed byte on the clock edge after a cycle with `cp_rd` high, and otherwise holds its value.
  - `host_rdata` does the same with `host_rd`.
- R3: While the overlay is enabled, a read at offset k (0..63) of the ROM window returns ROM data:
  - offset 0 returns 0xCD;
  - offset 62 returns the low byte of the ROM base address;
  - offset 63 returns the high byte of the ROM base address;
  - every other offset returns ((k*29) mod 256) XOR 0xA5.
- R4: A coprocessor write to address 0xF1 with bit 7 set disables the overlay. A write to 0xF1 with bit 7 clear enables it. The new state applies to reads issued from the next cycle on.
- R5: While the overlay is disabled, reads of the ROM window return RAM. RAM starts zero-filled, so an unwritten location there reads 0x00.
- R6: Coprocessor writes to the ROM window always update the RAM underneath, even while the overlay is enabled.
- R7: A coprocessor read of 0xF4+n (n = 0..3) returns the byte the host last wrote to port n.
- R8: A coprocessor write to 0xF4+n goes only to output latch n, which the host reads with `host_idx`=n. The write changes neither what the coprocessor reads at 0xF4+n nor the RAM.
- R9: If a host write and a coprocessor read hit the same port in the same cycle, the read returns the previous byte. The new byte is visible to reads issued from the next cycle on.
- R10: Every other address is plain RAM. A read returns the last byte written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cp_addr | input | ADDR_W | Coprocessor byte address |
| cp_wdata | input | 8 | Coprocessor write data |
| cp_we | input | 1 | Coprocessor write strobe |
| cp_rd | input | 1 | Coprocessor read strobe |
| cp_rdata | output | 8 | Coprocessor read data, one cycle after `cp_rd` |
| host_idx | input | 2 | Host mailbox port index |
| host_wdata | input | 8 | Host write data |
| host_we | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 8 | Host read data, one cycle after `host_rd` |

## Verification
The bench sweeps all 64 ROM offsets in three phases:
- with the overlay enabled, which separates the entry byte and the reset-vector bytes from the computed filler;
- after disabling the overlay, to show zero-filled RAM;
- after re-enabling it, to show that the earlier writes to the top page went to RAM and not into the ROM image.

Each mailbox port is then driven with distinct bytes from each side. This shows that the two directions are separate latches and that each index reaches its own latch. A host write that collides with a coprocessor read separates old-value from new-value visibility. Writes to plain RAM on both sides of the port window show that port writes do not leak into RAM.

// File: rtl/amap_pkg.sv
package amap_pkg;

    localparam int          ROM_AW        = 6;
    localparam int          ROM_BYTES     = 1 << ROM_AW;
    localparam int          MBX_PORTS     = 4;
    localparam int          MBX_IW        = 2;
    localparam logic [7:0]  CTRL_ADDR     = 8'hF1;
    localparam logic [7:0]  MBX_BASE      = 8'hF4;
    localparam int          CTRL_ROM_OFF  = 7;
    localparam logic [7:0]  ROM_ENTRY     = 8'hCD;

    typedef enum logic [1:0] {
        SRC_RAM  = 2'd0,
        SRC_ROM  = 2'd1,
        SRC_MBX  = 2'd2
    } rd_src_e;

    typedef struct packed {
        rd_src_e    src;
        logic [7:0] byte_q;
    } rd_stage_t;

    // Boot image byte at a window offset, with the reset vector pointing at the base.
    function automatic logic [7:0] rom_byte(input logic [ROM_AW-1:0] off,
                                            input logic [15:0] base);
        logic [7:0] b;
        if (off == '0)
            b = ROM_ENTRY;
        else if (off == ROM_AW'(ROM_BYTES - 2))
            b = base[7:0];
        else if (off == ROM_AW'(ROM_BYTES - 1))
            b = base[15:8];
        else
            b = 8'(32'(off) * 29) ^ 8'hA5;
        return b;
    endfunction

endpackage

// File: rtl/amap_ram.sv
module amap_ram #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    input  logic          we,
    input  logic          re,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
    end

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= 8'h00;
        else if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/amap_bootrom.sv
module amap_bootrom
    import amap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic [ROM_AW-1:0] off,
    output logic [7:0]        data
);
    localparam logic [15:0] BASE = 16'((1 << ADDR_W) - ROM_BYTES);

    always_comb data = rom_byte(off, BASE);
endmodule

// File: rtl/amap_mailbox.sv
module amap_mailbox
    import amap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MBX_IW-1:0] cp_idx,
    input  logic [7:0]        cp_wdata,
    input  logic              cp_we,
    output logic [7:0]        cp_byte,
    input  logic [MBX_IW-1:0] host_idx,
    input  logic [7:0]        host_wdata,
    input  logic              host_we,
    input  logic              host_rd,
    output logic [7:0]        host_rdata
);
    logic [7:0] to_cp_q   [MBX_PORTS];
    logic [7:0] to_host_q [MBX_PORTS];

    for (genvar p = 0; p < MBX_PORTS; p++) begin : g_port
        always_ff @(posedge clk) begin
            if (rst) begin
                to_cp_q[p]   <= 8'h00;
                to_host_q[p] <= 8'h00;
            end else begin
                if (host_we && host_idx == MBX_IW'(p)) to_cp_q[p]   <= host_wdata;
                if (cp_we   && cp_idx   == MBX_IW'(p)) to_host_q[p] <= cp_wdata;
            end
        end

        p_host_wr_r7: assert property (@(posedge clk) disable iff (rst)
            (host_we && host_idx == MBX_IW'(p)) |=> to_cp_q[p] == $past(host_wdata));
        p_cp_wr_r8: assert property (@(posedge clk) disable iff (rst)
            (cp_we && cp_idx == MBX_IW'(p)) |=> to_host_q[p] == $past(cp_wdata));
        p_inbound_hold_r8: assert property (@(posedge clk) disable iff (rst)
            !host_we |=> $stable(to_cp_q[p]));
    end

    always_comb cp_byte = to_cp_q[cp_idx];

    always_ff @(posedge clk) begin
        if (rst)          host_rdata <= 8'h00;
        else if (host_rd) host_rdata <= to_host_q[host_idx];
    end
endmodule

// File: rtl/amap_top.sv
module amap_top
    import amap_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cp_addr,
    input  logic [7:0]        cp_wdata,
    input  logic              cp_we,
    input  logic              cp_rd,
    output logic [7:0]        cp_rdata,
    input  logic [MBX_IW-1:0] host_idx,
    input  logic [7:0]        host_wdata,
    input  logic              host_we,
    input  logic              host_rd,
    output logic [7:0]        host_rdata
);
    localparam int ROM_TAG_W = ADDR_W - ROM_AW;
    localparam int MBX_TAG_W = ADDR_W - MBX_IW;
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
    localparam logic [MBX_TAG_W-1:0] MBX_TAG = MBX_TAG_W'(MBX_BASE >> MBX_IW);

    // address decode
    logic in_rom_win, in_mbx, is_ctrl;
    always_comb begin
        in_rom_win = &cp_addr[ADDR_W-1:ROM_AW];
        in_mbx     = cp_addr[ADDR_W-1:MBX_IW] == MBX_TAG;
        is_ctrl    = cp_addr == CTRL_A;
    end

    // overlay control
    logic rom_en;
    always_ff @(posedge clk) begin
        if (rst)                     rom_en <= 1'b1;
        else if (cp_we && is_ctrl)   rom_en <= ~cp_wdata[CTRL_ROM_OFF];
    end

    // storage
    logic [7:0] ram_q, rom_d, mbx_d;

    amap_ram #(.AW(ADDR_W)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .addr  (cp_addr),
        .wdata (cp_wdata),
        .we    (cp_we && !in_mbx),
        .re    (cp_rd),
        .rdata (ram_q)
    );

    amap_bootrom #(.ADDR_W(ADDR_W)) u_rom (
        .off  (cp_addr[ROM_AW-1:0]),
        .data (rom_d)
    );

    amap_mailbox u_mbx (
        .clk        (clk),
        .rst        (rst),
        .cp_idx     (cp_addr[MBX_IW-1:0]),
        .cp_wdata   (cp_wdata),
        .cp_we      (cp_we && in_mbx),
        .cp_byte    (mbx_d),
        .host_idx   (host_idx),
        .host_wdata (host_wdata),
        .host_we    (host_we),
        .host_rd    (host_rd),
        .host_rdata (host_rdata)
    );

    // read stage: source select registered with the data it needs
    rd_stage_t rd_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '{src: SRC_RAM, byte_q: 8'h00};
        end else if (cp_rd) begin
            if (in_mbx)                rd_q <= '{src: SRC_MBX, byte_q: mbx_d};
            else if (in_rom_win && rom_en) rd_q <= '{src: SRC_ROM, byte_q: rom_d};
            else                       rd_q <= '{src: SRC_RAM, byte_q: 8'h00};
        end
    end

    always_comb begin
        unique case (rd_q.src)
            SRC_ROM, SRC_MBX: cp_rdata = rd_q.byte_q;
            default:          cp_rdata = ram_q;
        endcase
    end

    p_reset_overlay_r1: assert property (@(posedge clk) rst |=> rom_en);
    p_reset_rdata_r1: assert property (@(posedge clk) rst |=> cp_rdata == 8'h00);
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cp_rd |=> $stable(cp_rdata));
    p_ctrl_write_r4: assert property (@(posedge clk) disable iff (rst)
        (cp_we && is_ctrl) |=> rom_en == !$past(cp_wdata[CTRL_ROM_OFF]));
    p_entry_byte_r3: assert property (@(posedge clk) disable iff (rst)
        (cp_rd && rom_en && in_rom_win && cp_addr[ROM_AW-1:0] == '0) |=> cp_rdata == ROM_ENTRY);
endmodule

// File: tb/amap_top_tb.sv
module amap_top_tb;
    localparam int AW = 11;
    localparam int BASE = (1 << AW) - 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cp_addr = '0;
    logic [7:0]    cp_wdata = '0;
    logic          cp_we = 1'b0, cp_rd = 1'b0;
    logic [7:0]    cp_rdata;
    logic [1:0]    host_idx = '0;
    logic [7:0]    host_wdata = '0;
    logic          host_we = 1'b0, host_rd = 1'b0;
    logic [7:0]    host_rdata;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    amap_top #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .cp_addr(cp_addr), .cp_wdata(cp_wdata),
        .cp_we(cp_we), .cp_rd(cp_rd), .cp_rdata(cp_rdata),
        .host_idx(host_idx), .host_wdata(host_wdata), .host_we(host_we),
        .host_rd(host_rd), .host_rdata(host_rdata)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_rom(input int k);
        if (k == 0)  return 8'hCD;
        if (k == 62) return 8'(BASE);
        if (k == 63) return 8'(BASE >> 8);
        return 8'(k * 29) ^ 8'hA5;
    endfunction

    task automatic cp_write(input int a, input logic [7:0] d);
        @(negedge clk);
        cp_addr = AW'(a); cp_wdata = d; cp_we = 1'b1;
        @(negedge clk);
        cp_we = 1'b0;
    endtask

    task automatic cp_read(input int a, output logic [7:0] d);
        @(negedge clk);
        cp_addr = AW'(a); cp_rd = 1'b1;
        @(negedge clk);
        cp_rd = 1'b0;
        d = cp_rdata;
    endtask

    task automatic host_write(input int i, input logic [7:0] d);
        @(negedge clk);
        host_idx = 2'(i); host_wdata = d; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_read(input int i, output logic [7:0] d);
        @(negedge clk);
        host_idx = 2'(i); host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got hung expected finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cp_rdata", cp_rdata, 8'h00);
        chk("R1 host_rdata", host_rdata, 8'h00);
        rst = 1'b0;
        for (int p = 0; p < 4; p++) begin
            cp_read(8'hF4 + p, d);  chk("R1 inbound latch", d, 8'h00);
            host_read(p, d);        chk("R1 outbound latch", d, 8'h00);
        end
        // R3 overlay on after reset, full sweep
        for (int k = 0; k < 64; k++) begin
            cp_read(BASE + k, d); chk("R3 rom byte", d, exp_rom(k));
        end
        // R2 hold while no read strobe
        repeat (3) @(negedge clk);
        chk("R2 hold", cp_rdata, exp_rom(63));
        // R6 writes into window while overlay active
        for (int k = 0; k < 64; k += 2) cp_write(BASE + k, 8'(k + 8'h30));
        cp_read(BASE, d); chk("R6 rom still visible", d, 8'hCD);
        // R4 disable overlay, R5/R6 RAM visible
        cp_write(8'hF1, 8'h80);
        for (int k = 0; k < 64; k++) begin
            cp_read(BASE + k, d);
            if (k % 2 == 0) chk("R6 ram under overlay", d, 8'(k + 8'h30));
            else            chk("R5 zero-filled", d, 8'h00);
        end
        // R4 re-enable
        cp_write(8'hF1, 8'h00);
        for (int k = 0; k < 64; k++) begin
            cp_read(BASE + k, d); chk("R4 rom re-enabled", d, exp_rom(k));
        end
        // R7 / R8 mailbox in both directions
        for (int p = 0; p < 4; p++) host_write(p, 8'h11 * (p + 1));
        for (int p = 0; p < 4; p++) cp_write(8'hF4 + p, 8'hA0 + 8'(p));
        for (int p = 0; p < 4; p++) begin
            cp_read(8'hF4 + p, d); chk("R7 inbound port", d, 8'h11 * (p + 1));
            host_read(p, d);       chk("R8 outbound port", d, 8'hA0 + 8'(p));
        end
        // R9 collision: host write and cp read same port, same cycle
        @(negedge clk);
        host_idx = 2'd2; host_wdata = 8'h5E; host_we = 1'b1;
        cp_addr = AW'(8'hF6); cp_rd = 1'b1;
        @(negedge clk);
        host_we = 1'b0; cp_rd = 1'b0;
        chk("R9 old value", cp_rdata, 8'h33);
        cp_read(8'hF6, d); chk("R9 new value", d, 8'h5E);
        // R10 plain RAM around the port window; R8 port writes do not leak
        cp_write(8'hF3, 8'h77); cp_write(8'hF8, 8'h88); cp_write(8'h010, 8'h42);
        cp_read(8'hF3, d);  chk("R10 ram F3", d, 8'h77);
        cp_read(8'hF8, d);  chk("R10 ram F8", d, 8'h88);
        cp_read(8'h010, d); chk("R10 ram low", d, 8'h42);
        cp_write(8'hF1, 8'h80);
        cp_read(BASE + 1, d); chk("R5 odd still zero", d, 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule